// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the 256-byte configuration header of one PCI function, either the endpoint layout (header type 0x00 or 0x80) or the bridge layout (any other header type, such as 0x01). The access decoder in front of it issues one request per cycle: a byte, word or dword read or write at an 8-bit offset. Reads return the addressed bytes in little-endian order one cycle later. Writes are applied byte by byte, and each byte is filtered by a write-protect rule that depends on the header type stored at offset 0x0E.

Aligned dword writes to a base address register with a nonzero configured region size are stored in sized form instead. The low address bits are cleared and the region's type bits are forced in. For the expansion ROM register the enable bit is kept. A one-cycle `update_mappings` pulse tells the surrounding logic that the command word or a base register changed.

A combinational decoder compares a probe address against the live base registers and the I/O and memory enables of the command byte, and reports which region claims it.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: Reset loads the vendor ID (bytes 0x00-0x01), device ID (0x02-0x03), revision (0x08), class code (0x09-0x0B, low byte first) and header type (0x0E) from parameters. All other bytes reset to zero. `rsp_valid` and `update_mappings` are low during reset.
- R2: A read request with size code 0, 1 or 2 returns 1, 2 or 4 bytes starting at the offset, lowest offset in bits 7:0 and unused upper bits zero. Size code 3 behaves as a dword. `rsp_valid` is high in exactly the cycle after each read request.
- R3: A write that is not a base-register store writes its bytes lowest first. Byte i of `req_wdata` (bits 8i+7:8i) goes to offset+i, for every byte that R4/R5 leave writable.
- R4: With header type 0x00 or 0x80, bytes 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x30-0x33 and 0x3D ignore byte-path writes.
- R5: With any other header type, bytes 0x00-0x03, 0x08-0x0B, 0x0E, 0x38-0x3B and 0x3D ignore byte-path writes. The bytes at 0x10-0x27 and 0x30-0x33 are writable.
- R6: A dword write at an aligned offset 0x10+4i (i = 0..5) whose region size S is nonzero stores `(wdata & ~(S-1)) | type`. Type bits are 1 for I/O and 8 for prefetchable memory.
- R7: A dword write at 0x30 with nonzero ROM size S stores `wdata & (~(S-1) | 1)`, so bit 0 (ROM enable) follows the written value.
- R8: A dword write to a base register whose region size is zero, or a word or byte write to a base register, takes the byte path of R3-R5.
- R9: `update_mappings` is high for one cycle after a write that made a base-register store (R6/R7), or whose byte range touches offset 0x04 or 0x05. Otherwise it is low.
- R10: `probe_hit` is set for region r when all of the following hold:
  - the base `B = word & ~(S-1)` is nonzero and `B+S-1` does not wrap;
  - for I/O regions (type bit 0, not the ROM) the last address is below 0x10000 and command bit 0 is set;
  - for memory regions the last address is not 0xFFFFFFFF and command bit 1 is set, and for the ROM (region 6) its bit 0 is also set;
  - `probe_io` matches the region kind;
  - `probe_addr & ~(S-1)` equals B.
  
  The lowest such region is reported in `probe_region`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset into the header |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| req_wdata | input | 32 | Write data, lowest byte for lowest offset |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, zero-extended |
| update_mappings | output | 1 | Command or base register changed |
| probe_addr | input | 32 | Address to decode |
| probe_io | input | 1 | 1 = I/O space probe, 0 = memory |
| probe_hit | output | 1 | Some region claims the probe |
| probe_region | output | 3 | Index of the claiming region |

## Verification
Read data and `rsp_valid` are registered at the edge that takes the request, and so is `update_mappings`; all three are due one cycle after the request cycle and gone a cycle later. The bench drives each request on a falling edge and samples those outputs at the next falling edge, then once more to confirm the pulse ended. The probe outputs are combinational on stored state, so they are sampled at the falling edge after the write that changed a base or command register, with the probe inputs already settled.

// File: rtl/cfg_hdr_pkg.sv
// Shared constants, access-size encoding and helpers for the configuration
// header register file. Assumes a fixed layout of six base registers and one
// expansion ROM register.
package cfg_hdr_pkg;

    localparam int NUM_BARS    = 6;
    localparam int NUM_REGIONS = NUM_BARS + 1;
    localparam int ROM_IDX     = NUM_BARS;
    localparam int CFG_BYTES   = 256;
    localparam int LANES       = 4;

    localparam logic [7:0] OFF_CMD_LO   = 8'h04;
    localparam logic [7:0] OFF_HDR_TYPE = 8'h0E;
    localparam logic [7:0] OFF_BAR0     = 8'h10;
    localparam logic [7:0] OFF_BAR_END  = OFF_BAR0 + 8'(4 * NUM_BARS);
    localparam logic [7:0] OFF_ROM      = 8'h30;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_DWORD = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_size_e;

    // Number of bytes moved by an access of the given size code.
    function automatic logic [2:0] acc_bytes(input logic [1:0] sz);
        case (sz)
            ACC_BYTE: return 3'd1;
            ACC_WORD: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

    // Header offset of the register that holds region r.
    function automatic logic [7:0] region_offset(input int r);
        if (r == ROM_IDX) return OFF_ROM;
        return OFF_BAR0 + 8'(4 * r);
    endfunction

endpackage

// File: rtl/cfg_wprot.sv
// Write-protect decode for one byte lane. Says whether a byte-path write may
// change the header byte at byte_addr, given the stored header type.
// Assumes header types 0x00/0x80 use the endpoint layout, all others the
// bridge layout.
module cfg_wprot
    import cfg_hdr_pkg::*;
(
    input  logic [7:0] hdr_type,
    input  logic [7:0] byte_addr,
    output logic       writable
);

    logic endpoint;
    logic common_ro;
    logic ep_ro;
    logic br_ro;

    // Classify the layout and the byte's protection group.
    always_comb begin
        endpoint  = (hdr_type == 8'h00) || (hdr_type == 8'h80);
        common_ro = (byte_addr inside {[8'h00:8'h03], [8'h08:8'h0B], OFF_HDR_TYPE, 8'h3D});
        ep_ro     = (byte_addr inside {[OFF_BAR0:OFF_BAR_END - 8'd1], [OFF_ROM:OFF_ROM + 8'd3]});
        br_ro     = (byte_addr inside {[8'h38:8'h3B]});
        writable  = !(common_ro || (endpoint ? ep_ro : br_ro));
    end

endmodule

// File: rtl/cfg_bar_store.sv
// Recognises an aligned dword write to a base or ROM register with a nonzero
// configured size and forms the sized value to store. Assumes every nonzero
// region size is a power of two.
module cfg_bar_store
    import cfg_hdr_pkg::*;
#(
    parameter logic [NUM_REGIONS*32-1:0] REGION_SIZES = '0,
    parameter logic [NUM_REGIONS*8-1:0]  REGION_TYPES = '0
) (
    input  logic [7:0]  offset,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    output logic        take,
    output logic [31:0] value
);

    logic        idx_ok;
    logic [2:0]  idx;
    logic [31:0] rsize;
    logic [7:0]  rtype;
    logic [31:0] keep_mask;

    // Map the offset to a region index; only aligned dword accesses qualify.
    always_comb begin
        idx_ok = 1'b0;
        idx    = '0;
        if (size[1] && offset[1:0] == 2'b00) begin
            if (offset >= OFF_BAR0 && offset < OFF_BAR_END) begin
                idx_ok = 1'b1;
                idx    = 3'((offset - OFF_BAR0) >> 2);
            end else if (offset == OFF_ROM) begin
                idx_ok = 1'b1;
                idx    = 3'(ROM_IDX);
            end
        end
    end

    // Form the stored value: size mask plus forced type or kept enable bit.
    always_comb begin
        rsize     = REGION_SIZES[int'(idx)*32 +: 32];
        rtype     = REGION_TYPES[int'(idx)*8 +: 8];
        keep_mask = ~(rsize - 32'd1);
        take      = idx_ok && (rsize != 32'd0);
        if (idx == 3'(ROM_IDX))
            value = wdata & (keep_mask | 32'd1);
        else
            value = (wdata & keep_mask) | {24'd0, rtype};
    end

endmodule

// File: rtl/cfg_region_decode.sv
// Address decode of the mapped regions. Each region is checked against its
// live register word and the command enables; the lowest index wins.
// Assumes power-of-two region sizes; a zero size disables a region.
module cfg_region_decode
    import cfg_hdr_pkg::*;
#(
    parameter logic [NUM_REGIONS*32-1:0] REGION_SIZES = '0,
    parameter logic [NUM_REGIONS*8-1:0]  REGION_TYPES = '0
) (
    input  logic [NUM_REGIONS*32-1:0] bar_words,
    input  logic                      io_en,
    input  logic                      mem_en,
    input  logic [31:0]               probe_addr,
    input  logic                      probe_io,
    output logic                      hit,
    output logic [2:0]                region
);

    logic [NUM_REGIONS-1:0] hit_vec;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        localparam logic [31:0] SZ    = REGION_SIZES[r*32 +: 32];
        localparam logic [31:0] MASK  = ~(SZ - 32'd1);
        localparam bit          IS_IO = (r != ROM_IDX) && REGION_TYPES[r*8];
        localparam bit          IS_ROM = (r == ROM_IDX);

        logic [31:0] word;
        logic [31:0] base;
        logic [31:0] last;
        logic        in_space;
        logic        enabled;

        // Validate the region's placement and compare the probe against it.
        always_comb begin
            word     = bar_words[r*32 +: 32];
            base     = word & MASK;
            last     = base + SZ - 32'd1;
            in_space = IS_IO ? (last < 32'h0001_0000) : (last != 32'hFFFF_FFFF);
            enabled  = IS_IO ? io_en : (mem_en && (!IS_ROM || word[0]));
            hit_vec[r] = (SZ != 32'd0) && (base != 32'd0) && (last > base) &&
                         in_space && enabled && (probe_io == IS_IO) &&
                         ((probe_addr & MASK) == base);
        end
    end

    // Lowest-index priority among claiming regions.
    always_comb begin
        hit    = 1'b0;
        region = '0;
        for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
            if (hit_vec[r]) begin
                hit    = 1'b1;
                region = 3'(r);
            end
        end
    end

endmodule

// File: rtl/cfg_hdr_regfile.sv
// Configuration header register file for one function. Serves byte, word and
// dword reads one cycle after the request, applies writes per byte lane under
// the header-type write-protect rule, stores sized base register values,
// pulses update_mappings and decodes probe addresses against the regions.
// Assumes at most one request per cycle and power-of-two region sizes.
module cfg_hdr_regfile
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'hA5C3,
    parameter logic [15:0] DEVICE_ID   = 16'h0E17,
    parameter logic [7:0]  REVISION_ID = 8'h04,
    parameter logic [23:0] CLASS_CODE  = 24'h0C0330,
    parameter logic [7:0]  HEADER_TYPE = 8'h00,
    parameter logic [NUM_REGIONS*32-1:0] REGION_SIZES =
        {32'h0001_0000, 32'h0, 32'h0, 32'h0, 32'h0010_0000, 32'h0000_0020, 32'h0000_1000},
    parameter logic [NUM_REGIONS*8-1:0] REGION_TYPES =
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h08, 8'h01, 8'h00}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_offset,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        update_mappings,
    input  logic [31:0] probe_addr,
    input  logic        probe_io,
    output logic        probe_hit,
    output logic [2:0]  probe_region
);

    logic [7:0]  cfg_q [CFG_BYTES];
    logic [7:0]  lane_addr [LANES];
    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] lane_wr_ok;
    logic [31:0] rd_word;
    logic [2:0]  nbytes;
    logic [8:0]  end_ext;
    logic        touch_cmd;
    logic        wr_fire;
    logic        rd_fire;
    logic        bar_take;
    logic [31:0] bar_value;
    logic        rsp_valid_q;
    logic [31:0] rsp_rdata_q;
    logic        upd_q;
    logic [NUM_REGIONS*32-1:0] bar_words;

    // Reset content of a header byte, taken from the identity parameters.
    function automatic logic [7:0] reset_byte(input int a);
        case (a)
            0:  return VENDOR_ID[7:0];
            1:  return VENDOR_ID[15:8];
            2:  return DEVICE_ID[7:0];
            3:  return DEVICE_ID[15:8];
            8:  return REVISION_ID;
            9:  return CLASS_CODE[7:0];
            10: return CLASS_CODE[15:8];
            11: return CLASS_CODE[23:16];
            14: return HEADER_TYPE;
            default: return 8'h00;
        endcase
    endfunction

    // Request qualifiers and the command-word overlap test.
    always_comb begin
        wr_fire   = req_valid && req_write;
        rd_fire   = req_valid && !req_write;
        nbytes    = acc_bytes(req_size);
        end_ext   = {1'b0, req_offset} + 9'(nbytes);
        touch_cmd = (end_ext > 9'(OFF_CMD_LO)) && (req_offset < OFF_CMD_LO + 8'd2);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Per-lane address, enable and read byte.
        always_comb begin
            lane_addr[l]     = req_offset + 8'(l);
            lane_en[l]       = (3'(l) < nbytes);
            rd_word[l*8 +: 8] = lane_en[l] ? cfg_q[lane_addr[l]] : 8'h00;
        end

        cfg_wprot u_wprot (
            .hdr_type  (cfg_q[OFF_HDR_TYPE]),
            .byte_addr (lane_addr[l]),
            .writable  (lane_wr_ok[l])
        );
    end

    cfg_bar_store #(
        .REGION_SIZES (REGION_SIZES),
        .REGION_TYPES (REGION_TYPES)
    ) u_bar_store (
        .offset (req_offset),
        .size   (req_size),
        .wdata  (req_wdata),
        .take   (bar_take),
        .value  (bar_value)
    );

    // Header storage: reset image, sized base stores or protected byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < CFG_BYTES; a++) cfg_q[a] <= reset_byte(a);
        end else if (wr_fire) begin
            for (int l = 0; l < LANES; l++) begin
                if (bar_take)
                    cfg_q[lane_addr[l]] <= bar_value[l*8 +: 8];
                else if (lane_en[l] && lane_wr_ok[l])
                    cfg_q[lane_addr[l]] <= req_wdata[l*8 +: 8];
            end
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= rd_fire;
            if (rd_fire) rsp_rdata_q <= rd_word;
        end
    end

    // Mapping update pulse after base stores or command-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= wr_fire && (bar_take || touch_cmd);
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_word
        localparam logic [7:0] RO = region_offset(r);
        assign bar_words[r*32 +: 32] = {cfg_q[RO + 8'd3], cfg_q[RO + 8'd2],
                                        cfg_q[RO + 8'd1], cfg_q[RO]};
    end

    cfg_region_decode #(
        .REGION_SIZES (REGION_SIZES),
        .REGION_TYPES (REGION_TYPES)
    ) u_decode (
        .bar_words  (bar_words),
        .io_en      (cfg_q[OFF_CMD_LO][0]),
        .mem_en     (cfg_q[OFF_CMD_LO][1]),
        .probe_addr (probe_addr),
        .probe_io   (probe_io),
        .hit        (probe_hit),
        .region     (probe_region)
    );

    assign rsp_valid       = rsp_valid_q;
    assign rsp_rdata       = rsp_rdata_q;
    assign update_mappings = upd_q;

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R2
    AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R2
    AST_UPD_HAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        update_mappings |-> $past(req_valid && req_write)); // R9
    AST_UPD_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_offset == OFF_CMD_LO) |=> update_mappings); // R9
    AST_ID_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(cfg_q[0]) && $stable(cfg_q[1]) &&
                          $stable(cfg_q[2]) && $stable(cfg_q[3]))); // R1
    AST_HDR_TYPE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q[OFF_HDR_TYPE])); // R4
    AST_IO_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_hit && probe_io) |-> cfg_q[OFF_CMD_LO][0]); // R10

endmodule

// File: tb/cfg_hdr_regfile_bench.sv
module cfg_hdr_regfile_bench;
    import cfg_hdr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_ep = 1'b0;
    logic        vld_br = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_offset = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] probe_addr = '0;
    logic        probe_io = 1'b0;

    logic        ep_rsp_valid, br_rsp_valid;
    logic [31:0] ep_rdata, br_rdata;
    logic        ep_upd, br_upd;
    logic        ep_hit, br_hit;
    logic [2:0]  ep_region, br_region;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cfg_hdr_regfile u_cfg_hdr_regfile (
        .clk(clk), .rst_n(rst_n), .req_valid(vld_ep), .req_write(req_write),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(ep_rsp_valid), .rsp_rdata(ep_rdata), .update_mappings(ep_upd),
        .probe_addr(probe_addr), .probe_io(probe_io),
        .probe_hit(ep_hit), .probe_region(ep_region)
    );

    cfg_hdr_regfile #(
        .HEADER_TYPE (8'h01),
        .REGION_SIZES ('0),
        .REGION_TYPES ('0)
    ) u_cfg_hdr_regfile_bridge (
        .clk(clk), .rst_n(rst_n), .req_valid(vld_br), .req_write(req_write),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(br_rsp_valid), .rsp_rdata(br_rdata), .update_mappings(br_upd),
        .probe_addr(probe_addr), .probe_io(probe_io),
        .probe_hit(br_hit), .probe_region(br_region)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [7:0]  off;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd2, 8'h00, 32'h0,        32'h0E17A5C3, 4'd1},  // R1 ids
        '{1'b0, 2'd1, 8'h02, 32'h0,        32'h00000E17, 4'd2},  // R2 word
        '{1'b0, 2'd0, 8'h08, 32'h0,        32'h00000004, 4'd1},  // R1 revision
        '{1'b0, 2'd2, 8'h08, 32'h0,        32'h0C033004, 4'd1},  // R1 class
        '{1'b0, 2'd0, 8'h0E, 32'h0,        32'h00000000, 4'd1},  // R1 header type
        '{1'b1, 2'd2, 8'h00, 32'hFFFFFFFF, 32'h0,        4'd4},
        '{1'b0, 2'd2, 8'h00, 32'h0,        32'h0E17A5C3, 4'd4},  // R4 ids protected
        '{1'b1, 2'd2, 8'h3C, 32'h12345678, 32'h0,        4'd4},
        '{1'b0, 2'd2, 8'h3C, 32'h0,        32'h12340078, 4'd4},  // R4 0x3D protected
        '{1'b1, 2'd1, 8'h40, 32'hCAFEBEEF, 32'h0,        4'd3},
        '{1'b0, 2'd2, 8'h40, 32'h0,        32'h0000BEEF, 4'd3},  // R3 word write
        '{1'b1, 2'd0, 8'h43, 32'h000000A5, 32'h0,        4'd3},
        '{1'b0, 2'd2, 8'h40, 32'h0,        32'hA500BEEF, 4'd3},  // R3 byte write
        '{1'b1, 2'd2, 8'h10, 32'hFFFFFFFF, 32'h0,        4'd6},
        '{1'b0, 2'd2, 8'h10, 32'h0,        32'hFFFFF000, 4'd6},  // R6 memory bar
        '{1'b1, 2'd2, 8'h14, 32'hFFFFFFFF, 32'h0,        4'd6},
        '{1'b0, 2'd2, 8'h14, 32'h0,        32'hFFFFFFE1, 4'd6},  // R6 io bar
        '{1'b1, 2'd2, 8'h18, 32'h12345678, 32'h0,        4'd6},
        '{1'b0, 2'd2, 8'h18, 32'h0,        32'h12300008, 4'd6},  // R6 prefetch bar
        '{1'b1, 2'd2, 8'h1C, 32'hDEADBEEF, 32'h0,        4'd8},
        '{1'b0, 2'd2, 8'h1C, 32'h0,        32'h00000000, 4'd8},  // R8 zero size
        '{1'b1, 2'd1, 8'h10, 32'h0000ABCD, 32'h0,        4'd8},
        '{1'b0, 2'd2, 8'h10, 32'h0,        32'hFFFFF000, 4'd8},  // R8 word to bar
        '{1'b1, 2'd2, 8'h30, 32'hFFFFFFFF, 32'h0,        4'd7},
        '{1'b0, 2'd2, 8'h30, 32'h0,        32'hFFFF0001, 4'd7},  // R7 rom enable kept
        '{1'b1, 2'd2, 8'h30, 32'h000A5FFE, 32'h0,        4'd7},
        '{1'b0, 2'd2, 8'h30, 32'h0,        32'h000A0000, 4'd7},  // R7 rom disabled
        '{1'b0, 2'd1, 8'h11, 32'h0,        32'h0000FFF0, 4'd2},  // R2 unaligned word
        '{1'b0, 2'd0, 8'h3E, 32'h0,        32'h00000034, 4'd3},  // R3 byte order
        '{1'b1, 2'd3, 8'h44, 32'h11223344, 32'h0,        4'd2},
        '{1'b0, 2'd3, 8'h44, 32'h0,        32'h11223344, 4'd2},  // R2 size code 3
        '{1'b0, 2'd0, 8'h44, 32'h0,        32'h00000044, 4'd2}   // R2 byte read
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request to the endpoint (br=0) or bridge (br=1) copy; returns at the
    // falling edge after the edge that took it.
    task automatic do_req(input bit br, input logic wr, input logic [1:0] sz,
                          input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        vld_ep = !br; vld_br = br;
        req_write = wr; req_size = sz; req_offset = off; req_wdata = d;
        @(negedge clk);
        vld_ep = 1'b0; vld_br = 1'b0; req_write = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input logic io,
                         input logic exp_hit, input logic [2:0] exp_reg, input string tag);
        probe_addr = a; probe_io = io;
        #1;
        check(tag, {28'd0, ep_hit, ep_region}, {28'd0, exp_hit, exp_hit ? exp_reg : ep_region});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", {31'd0, ep_rsp_valid}, 32'd0);
        check("R1 update in reset", {31'd0, ep_upd}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            do_req(1'b0, VECS[i].wr, VECS[i].sz, VECS[i].off, VECS[i].data);
            if (!VECS[i].wr)
                check($sformatf("R%0d vector %0d", VECS[i].req, i), ep_rdata, VECS[i].exp);
        end

        // R2 valid timing
        do_req(1'b0, 1'b0, 2'd0, 8'h00, 32'h0);
        check("R2 rsp_valid after read", {31'd0, ep_rsp_valid}, 32'd1);
        @(negedge clk);
        check("R2 rsp_valid drops", {31'd0, ep_rsp_valid}, 32'd0);

        // R9 update pulse
        do_req(1'b0, 1'b1, 2'd0, 8'h3C, 32'h55);
        check("R9 no update for plain byte", {31'd0, ep_upd}, 32'd0);
        do_req(1'b0, 1'b1, 2'd2, 8'h04, 32'h00000003);
        check("R9 update after command write", {31'd0, ep_upd}, 32'd1);
        @(negedge clk);
        check("R9 update is one cycle", {31'd0, ep_upd}, 32'd0);
        do_req(1'b0, 1'b1, 2'd1, 8'h03, 32'h00000300);
        check("R9 update for word at 0x03", {31'd0, ep_upd}, 32'd1);
        do_req(1'b0, 1'b1, 2'd0, 8'h06, 32'h0);
        check("R9 no update at 0x06", {31'd0, ep_upd}, 32'd0);
        do_req(1'b0, 1'b1, 2'd2, 8'h1C, 32'h0);
        check("R9 no update zero-size bar", {31'd0, ep_upd}, 32'd0);
        do_req(1'b0, 1'b1, 2'd2, 8'h14, 32'h0000C000);
        check("R9 update after bar store", {31'd0, ep_upd}, 32'd1);

        // R10 decode
        probe(32'h0000C01F, 1'b1, 1'b1, 3'd1, "R10 io hit region 1");
        probe(32'h0000C020, 1'b1, 1'b0, 3'd0, "R10 io miss past end");
        probe(32'h0000C01F, 1'b0, 1'b0, 3'd0, "R10 memory probe of io base");
        probe(32'hFFFFF010, 1'b0, 1'b0, 3'd0, "R10 bar ending at top invalid");
        probe(32'h123FFFF0, 1'b0, 1'b1, 3'd2, "R10 prefetch hit region 2");
        do_req(1'b0, 1'b1, 2'd2, 8'h10, 32'hE0000000);
        probe(32'hE0000FFC, 1'b0, 1'b1, 3'd0, "R10 memory hit region 0");
        probe(32'h000A0010, 1'b0, 1'b0, 3'd0, "R10 rom disabled");
        do_req(1'b0, 1'b1, 2'd2, 8'h30, 32'h000A0001);
        probe(32'h000A0010, 1'b0, 1'b1, 3'd6, "R10 rom enabled");
        do_req(1'b0, 1'b1, 2'd1, 8'h04, 32'h0);
        probe(32'h0000C01F, 1'b1, 1'b0, 3'd0, "R10 io disabled by command");
        probe(32'hE0000FFC, 1'b0, 1'b0, 3'd0, "R10 memory disabled by command");

        // R5 bridge layout
        do_req(1'b1, 1'b0, 2'd0, 8'h0E, 32'h0);
        check("R5 bridge header type", br_rdata, 32'h00000001);
        do_req(1'b1, 1'b1, 2'd2, 8'h10, 32'hFFFFFFFF);
        do_req(1'b1, 1'b0, 2'd2, 8'h10, 32'h0);
        check("R5 bridge 0x10 writable", br_rdata, 32'hFFFFFFFF);
        do_req(1'b1, 1'b1, 2'd2, 8'h30, 32'h11223344);
        do_req(1'b1, 1'b0, 2'd2, 8'h30, 32'h0);
        check("R5 bridge 0x30 writable", br_rdata, 32'h11223344);
        do_req(1'b1, 1'b1, 2'd2, 8'h38, 32'hFFFFFFFF);
        do_req(1'b1, 1'b0, 2'd2, 8'h38, 32'h0);
        check("R5 bridge 0x38 protected", br_rdata, 32'h00000000);
        do_req(1'b1, 1'b1, 2'd2, 8'h08, 32'hFFFFFFFF);
        do_req(1'b1, 1'b0, 2'd2, 8'h08, 32'h0);
        check("R5 bridge class protected", br_rdata, 32'h0C033004);

        // R1 reset again
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        do_req(1'b0, 1'b0, 2'd2, 8'h3C, 32'h0);
        check("R1 byte cleared by reset", ep_rdata, 32'h00000000);
        do_req(1'b0, 1'b0, 2'd2, 8'h10, 32'h0);
        check("R1 bar cleared by reset", ep_rdata, 32'h00000000);
        do_req(1'b0, 1'b0, 2'd2, 8'h00, 32'h0);
        check("R1 ids after reset", ep_rdata, 32'h0E17A5C3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule